// File: doc/BRIEF.md
# Multiplexed-Bus Parallel Port Expander Core

This block is the host side of a parallel I/O expander that hangs off a processor bus on which address and data share the same eight wires. The host first puts an address on the bus with the address strobe `ale` high. The block keeps the last address seen while `ale` is high. Active-low select, read and write strobes then move a byte into or out of the addressed register. All bus inputs are sampled on the system clock `clk`, and a write takes effect when the write strobe returns high.

The block holds the data registers of one fine-grained port (port 0) and of five wide ports (1 to 5). Each wide port has a single direction bit that covers all of its pins. An output port drives its data register, and reading an input port returns its pins as they are at that moment. Port 0 keeps a per-bit direction register, a latch-mode register and a control register. Its pin logic lives in a neighbouring block, which gets these registers through taps and returns its input view on `pa_view`. Every register can be read back. Any port can be reached a whole byte at a time or one bit at a time.

The bus side is a five-state machine. `S_IDLE` is the state after reset, with no address yet. `S_ADDR` means the address strobe is high. `S_HELD` means an address is latched and no transfer is under way. `S_READ` means the block is driving the bus. `S_WRITE` means the write strobe is low. The transitions are:
- `S_IDLE`→`S_ADDR` when `ale` is high.
- `S_ADDR`→`S_HELD` when `ale` is low.
- `S_HELD`→`S_ADDR` when `ale` is high. This has the highest priority.
- `S_HELD`→`S_READ` when select and read are both low.
- `S_HELD`→`S_WRITE` when select and write are both low.
- `S_READ`→`S_HELD` when select or read goes high.
- `S_WRITE`→`S_HELD` with a commit when write goes high while select is still low.
- `S_WRITE`→`S_HELD` with no commit when select goes high first.

Top module: `pexp_core`

## Requirements
- R1: While `rst_n` is low, every register is zero. All of `pins_oe` is 0, so every port is an input, and `ad_oe` is 0.
- R2: The latched address is the value of `ad_in` at the last clock edge where `ale` was high. It stays unchanged while `ale` is low.
- R3: With `cs_n` high, no transfer takes place. `ad_oe` stays 0, and a write whose `cs_n` rises before `wr_n` changes no register.
- R4: `ad_oe` rises one clock after an edge at which `cs_n` and `rd_n` are both low with an address latched. It falls one clock after an edge at which `rd_n` or `cs_n` is high. While it is high, `ad_out` shows the addressed register.
- R5: A write commits at the first clock edge at which `wr_n` is high again with `cs_n` still low. The register shows the new value from the next cycle on. The value written is `ad_in` at the last edge with `wr_n` low, and holding `wr_n` low changes nothing.
- R6: Bit k of the configuration register (address 9, k = 0..4) sets the direction of wide port k+1, where 1 means output. An output port drives all 8 bits of `pins_oe` high and drives its data register on `pins_out`. An input port drives `pins_oe` low. Wide port k+1 occupies bits [8k+7:8k] of `pins_in`, `pins_out` and `pins_oe`.
- R7: Reading the data register of wide port p (byte address p, 1..5) returns the register if the port is an output. Otherwise it returns the port's `pins_in` slice.
- R8: Reading byte address 0 returns, bit by bit, the port 0 data register where `pa_dir` is 1 and `pa_view` where it is 0.
- R9: Byte mode applies when address bit 7 is 0 and bits 6:4 are 0. Address bits 3:0 select one of ten registers: data of ports 0 to 5 at 0 to 5, port 0 direction at 6, port 0 latch mode at 7, port 0 control at 8, and configuration at 9. Every other byte-mode address reads 0 and ignores writes.
- R10: Bit mode applies when address bit 7 is 1. Address bits 6:4 select the port (0..5), bits 2:0 select the bit, and bit 3 is ignored. A bit-mode write copies `ad_in` bit 0 into the selected data bit and leaves the other seven bits unchanged. Port numbers 6 and 7 ignore writes.
- R11: A bit-mode read returns the selected bit of the port's read value (as in R7 and R8) in position 0, with zeros elsewhere. Port numbers 6 and 7 read 0.
- R12: `pa_data`, `pa_dir`, `pa_latch`, `pa_ctrl` and `pa_cfg` (configuration bits 7:5) always equal the registers they tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; address captured while high |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Shared address/data bus, input side |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus drive enable for `ad_out` |
| pa_view | input | 8 | Input view of port 0 from its pin block |
| pa_data | output | 8 | Port 0 data register tap |
| pa_dir | output | 8 | Port 0 per-bit direction tap (1 = output) |
| pa_latch | output | 8 | Port 0 latch-mode register tap |
| pa_ctrl | output | 8 | Port 0 control register tap |
| pa_cfg | output | 3 | Configuration bits 7:5 (strobe and interrupt settings) |
| pins_in | input | 40 | Pin levels of wide ports 1..5 |
| pins_out | output | 40 | Output data of wide ports 1..5 |
| pins_oe | output | 40 | Output enables of wide ports 1..5 |

## Verification
The assertions assume that the bus strobes are synchronous to `clk` and change at most once per cycle. They also assume that `ad_in` is held for at least one sampled edge in each address and data phase, so that each strobe level seen by the state machine is a real bus phase. The bench drives every input on the falling clock edge and holds each phase for a full cycle, so each phase is seen by exactly one or more rising edges. Select always falls after the address phase ends. The random part keeps to this discipline and varies only addresses, data, pin levels and the order of operations. The directed part adds the aborted write, the read without select, the changing address and write data, and unmapped addresses.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

    localparam int DW       = 8;
    localparam int MAX_WIDE = 5;

    localparam logic [3:0] REG_DIRA = 4'd6;
    localparam logic [3:0] REG_LATA = 4'd7;
    localparam logic [3:0] REG_CTLA = 4'd8;
    localparam logic [3:0] REG_CFG  = 4'd9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_HELD,
        S_READ,
        S_WRITE
    } bus_state_t;

endpackage

// File: rtl/pexp_bus_fsm.sv
module pexp_bus_fsm
    import pexp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] lat_addr,
    output logic [DW-1:0] wdata,
    output logic          commit,
    output logic          drive
);

    bus_state_t state, state_nxt;
    logic       addr_en;
    logic       data_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (ale) state_nxt = S_ADDR;
            S_ADDR:  if (!ale) state_nxt = S_HELD;
            S_HELD: begin
                if (ale)                  state_nxt = S_ADDR;
                else if (!cs_n && !rd_n)  state_nxt = S_READ;
                else if (!cs_n && !wr_n)  state_nxt = S_WRITE;
            end
            S_READ:  if (cs_n || rd_n) state_nxt = S_HELD;
            S_WRITE: if (cs_n || wr_n) state_nxt = S_HELD;
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drive   = 1'b0;
        commit  = 1'b0;
        addr_en = 1'b0;
        data_en = 1'b0;
        unique case (state)
            S_IDLE:  addr_en = ale;
            S_ADDR:  addr_en = ale;
            S_HELD: begin
                addr_en = ale;
                data_en = !ale && !cs_n && !wr_n && rd_n;
            end
            S_READ:  drive = 1'b1;
            S_WRITE: begin
                data_en = !cs_n && !wr_n;
                commit  = !cs_n && wr_n;
            end
            default: ;
        endcase
    end

    // address latch: follows the bus while the strobe is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_addr <= '0;
        else if (addr_en) lat_addr <= ad_in;
    end

    // write data: last value seen while the write strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wdata <= '0;
        else if (data_en) wdata <= ad_in;
    end

endmodule

// File: rtl/pexp_regfile.sv
module pexp_regfile
    import pexp_pkg::*;
#(
    parameter int NUM_WIDE = MAX_WIDE,
    localparam int NP      = NUM_WIDE + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [DW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [NP-1:0][DW-1:0]  data_q,
    output logic [DW-1:0]          dira_q,
    output logic [DW-1:0]          lata_q,
    output logic [DW-1:0]          ctla_q,
    output logic [DW-1:0]          cfg_q
);

    logic       byte_hit;
    logic       bit_hit;
    logic [2:0] sel_port;
    logic [2:0] sel_bit;

    assign byte_hit = commit && !addr[7] && (addr[6:4] == 3'd0);
    assign bit_hit  = commit && addr[7];
    assign sel_port = addr[6:4];
    assign sel_bit  = addr[2:0];

    // per-port data registers
    for (genvar g = 0; g < NP; g++) begin : g_port
        logic [DW-1:0] q;
        logic          we_byte;
        logic          we_bit;

        assign we_byte = byte_hit && (addr[3:0] == 4'(g));
        assign we_bit  = bit_hit && (sel_port == 3'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (we_byte) q <= wdata;
            else if (we_bit)  q[sel_bit] <= wdata[0];
        end

        assign data_q[g] = q;
    end

    // port 0 control registers and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dira_q <= '0;
            lata_q <= '0;
            ctla_q <= '0;
            cfg_q  <= '0;
        end else if (byte_hit) begin
            unique case (addr[3:0])
                REG_DIRA: dira_q <= wdata;
                REG_LATA: lata_q <= wdata;
                REG_CTLA: ctla_q <= wdata;
                REG_CFG:  cfg_q  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/pexp_read_mux.sv
module pexp_read_mux
    import pexp_pkg::*;
#(
    parameter int NUM_WIDE = MAX_WIDE,
    localparam int NP      = NUM_WIDE + 1,
    localparam int PW      = NUM_WIDE * DW
) (
    input  logic [DW-1:0]         addr,
    input  logic [NP-1:0][DW-1:0] data_q,
    input  logic [DW-1:0]         dira_q,
    input  logic [DW-1:0]         lata_q,
    input  logic [DW-1:0]         ctla_q,
    input  logic [DW-1:0]         cfg_q,
    input  logic [DW-1:0]         pa_view,
    input  logic [PW-1:0]         pins_in,
    output logic [DW-1:0]         rdata
);

    logic [NP-1:0][DW-1:0] view;

    // value a read of each port returns
    for (genvar g = 0; g < NP; g++) begin : g_view
        if (g == 0) begin : g_fine
            assign view[g] = (data_q[g] & dira_q) | (pa_view & ~dira_q);
        end else begin : g_wide
            assign view[g] = cfg_q[g-1] ? data_q[g] : pins_in[(g-1)*DW +: DW];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[7]) begin
            for (int i = 0; i < NP; i++) begin
                if (addr[6:4] == 3'(i)) rdata[0] = view[i][addr[2:0]];
            end
        end else if (addr[6:4] == 3'd0) begin
            for (int i = 0; i < NP; i++) begin
                if (addr[3:0] == 4'(i)) rdata = view[i];
            end
            unique case (addr[3:0])
                REG_DIRA: rdata = dira_q;
                REG_LATA: rdata = lata_q;
                REG_CTLA: rdata = ctla_q;
                REG_CFG:  rdata = cfg_q;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/pexp_core.sv
module pexp_core
    import pexp_pkg::*;
#(
    parameter int NUM_WIDE = MAX_WIDE,
    localparam int NP      = NUM_WIDE + 1,
    localparam int PW      = NUM_WIDE * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] pa_view,
    output logic [DW-1:0] pa_data,
    output logic [DW-1:0] pa_dir,
    output logic [DW-1:0] pa_latch,
    output logic [DW-1:0] pa_ctrl,
    output logic [2:0]    pa_cfg,
    input  logic [PW-1:0] pins_in,
    output logic [PW-1:0] pins_out,
    output logic [PW-1:0] pins_oe
);

    logic [DW-1:0]         lat_addr;
    logic [DW-1:0]         wdata;
    logic                  commit;
    logic                  drive;
    logic [NP-1:0][DW-1:0] data_q;
    logic [DW-1:0]         dira_q;
    logic [DW-1:0]         lata_q;
    logic [DW-1:0]         ctla_q;
    logic [DW-1:0]         cfg_q;
    logic [DW-1:0]         rdata;

    pexp_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ad_in    (ad_in),
        .lat_addr (lat_addr),
        .wdata    (wdata),
        .commit   (commit),
        .drive    (drive)
    );

    pexp_regfile #(.NUM_WIDE(NUM_WIDE)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .addr   (lat_addr),
        .wdata  (wdata),
        .data_q (data_q),
        .dira_q (dira_q),
        .lata_q (lata_q),
        .ctla_q (ctla_q),
        .cfg_q  (cfg_q)
    );

    pexp_read_mux #(.NUM_WIDE(NUM_WIDE)) u_rmux (
        .addr    (lat_addr),
        .data_q  (data_q),
        .dira_q  (dira_q),
        .lata_q  (lata_q),
        .ctla_q  (ctla_q),
        .cfg_q   (cfg_q),
        .pa_view (pa_view),
        .pins_in (pins_in),
        .rdata   (rdata)
    );

    assign ad_out   = rdata;
    assign ad_oe    = drive;
    assign pa_data  = data_q[0];
    assign pa_dir   = dira_q;
    assign pa_latch = lata_q;
    assign pa_ctrl  = ctla_q;
    assign pa_cfg   = cfg_q[7:5];

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_pins
        assign pins_out[g*DW +: DW] = data_q[g+1];
        assign pins_oe[g*DW +: DW]  = {DW{cfg_q[g]}};
    end

endmodule

// File: rtl/pexp_core_chk.sv
module pexp_core_chk
    import pexp_pkg::*;
#(
    parameter int NUM_WIDE = MAX_WIDE,
    localparam int PW      = NUM_WIDE * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ad_oe,
    input logic          commit,
    input logic [DW-1:0] lat_addr,
    input logic [PW-1:0] pins_oe,
    input logic [PW-1:0] pins_out
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (pins_oe == '0 && !ad_oe));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale) |-> $stable(lat_addr));

    p_drive_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!$past(cs_n) && !$past(rd_n)));

    p_drive_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && (rd_n || cs_n)) |=> !ad_oe);

    p_commit_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !$past(wr_n));

    p_pins_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> ($stable(pins_out) && $stable(pins_oe)));

endmodule

bind pexp_core pexp_core_chk #(.NUM_WIDE(NUM_WIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_oe    (ad_oe),
    .commit   (commit),
    .lat_addr (lat_addr),
    .pins_oe  (pins_oe),
    .pins_out (pins_out)
);

// File: tb/pexp_core_test.sv
module pexp_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  pa_view = '0;
    logic [7:0]  pa_data, pa_dir, pa_latch, pa_ctrl;
    logic [2:0]  pa_cfg;
    logic [39:0] pins_in = '0;
    logic [39:0] pins_out, pins_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_data [6];
    logic [7:0] m_dira, m_lata, m_ctla, m_cfg;

    always #10 clk = ~clk;

    pexp_core uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .pa_view(pa_view), .pa_data(pa_data), .pa_dir(pa_dir),
        .pa_latch(pa_latch), .pa_ctrl(pa_ctrl), .pa_cfg(pa_cfg),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] port_val(input int p);
        if (p == 0) return (m_data[0] & m_dira) | (pa_view & ~m_dira);
        return m_cfg[p-1] ? m_data[p] : pins_in[(p-1)*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int p;
        if (a[7]) begin
            p = int'(a[6:4]);
            if (p > 5) return 8'h00;
            return {7'b0, port_val(p)[a[2:0]]};
        end
        if (a[6:4] != 3'd0) return 8'h00;
        case (a[3:0])
            4'd6:    return m_dira;
            4'd7:    return m_lata;
            4'd8:    return m_ctla;
            4'd9:    return m_cfg;
            default: return (a[3:0] < 4'd6) ? port_val(int'(a[3:0])) : 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int p;
        if (a[7]) begin
            p = int'(a[6:4]);
            if (p <= 5) m_data[p][a[2:0]] = d[0];
        end else if (a[6:4] == 3'd0) begin
            case (a[3:0])
                4'd6: m_dira = d;
                4'd7: m_lata = d;
                4'd8: m_ctla = d;
                4'd9: m_cfg  = d;
                default: if (a[3:0] < 4'd6) m_data[int'(a[3:0])] = d;
            endcase
        end
    endtask

    function automatic logic [39:0] exp_oe();
        logic [39:0] v;
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = {8{m_cfg[k]}};
        return v;
    endfunction

    function automatic logic [39:0] exp_out();
        logic [39:0] v;
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = m_data[k+1];
        return v;
    endfunction

    task automatic set_addr(input logic [7:0] a);
        @(negedge clk);
        ale = 1'b1; ad_in = a;
        @(negedge clk);
        ale = 1'b0; ad_in = 8'($urandom);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        set_addr(a);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; ad_in = d;
        @(negedge clk);
        wr_n = 1'b1; ad_in = 8'($urandom);
        @(negedge clk);
        cs_n = 1'b1;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        logic [7:0] got;
        logic       oe;
        set_addr(a);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        got = ad_out; oe = ad_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        check(oe === 1'b1, "R4 drive enable during read", 64'(oe), 64'd1);
        check(got === exp_read(a), tag, 64'(got), 64'(exp_read(a)));
        @(negedge clk);
        check(ad_oe === 1'b0, "R4 drive released", 64'(ad_oe), 64'd0);
    endtask

    task automatic check_pins(input string tag);
        check(pins_oe === exp_oe(), tag, 64'(pins_oe), 64'(exp_oe()));
        check(pins_out === exp_out(), tag, 64'(pins_out), 64'(exp_out()));
    endtask

    task automatic check_taps();
        check(pa_data === m_data[0], "R12 data tap", 64'(pa_data), 64'(m_data[0]));
        check(pa_dir === m_dira, "R12 dir tap", 64'(pa_dir), 64'(m_dira));
        check(pa_latch === m_lata, "R12 latch tap", 64'(pa_latch), 64'(m_lata));
        check(pa_ctrl === m_ctla, "R12 ctrl tap", 64'(pa_ctrl), 64'(m_ctla));
        check(pa_cfg === m_cfg[7:5], "R12 cfg tap", 64'(pa_cfg), 64'(m_cfg[7:5]));
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) m_data[i] = '0;
        m_dira = '0; m_lata = '0; m_ctla = '0; m_cfg = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pins_oe === '0, "R1 reset oe", 64'(pins_oe), 64'd0);
        check(ad_oe === 1'b0, "R1 reset bus drive", 64'(ad_oe), 64'd0);
        check_taps();
        rst_n = 1'b1;
        pins_in = {8'h5A, 8'h0F, 8'hC3, 8'h96, 8'h3E};
        pa_view = 8'h99;

        // R6/R7: directions and port reads
        bus_write(8'h09, 8'h03);
        check_pins("R6 direction from config");
        bus_write(8'h01, 8'hA5);
        check_pins("R6 output data on pins");
        bus_read(8'h01, "R7 output port reads register");
        bus_read(8'h03, "R7 input port reads pins");

        // R8: port 0 mixed directions
        bus_write(8'h06, 8'hF0);
        bus_write(8'h00, 8'h3C);
        bus_read(8'h00, "R8 port 0 mixed read");
        bus_write(8'h07, 8'h81);
        bus_write(8'h08, 8'h42);
        bus_write(8'h09, 8'hE3);
        check_taps();

        // R9: unmapped addresses
        bus_write(8'h0A, 8'hFF);
        bus_write(8'h15, 8'hFF);
        bus_read(8'h0A, "R9 unmapped reads zero");
        bus_read(8'h15, "R9 upper bits set reads zero");
        for (int r = 0; r < 10; r++) bus_read(8'(r), "R9 map after unmapped writes");

        // R10/R11: bit mode on port 1
        bus_write(8'h92, 8'hFE);
        check_pins("R10 bit clear");
        bus_write(8'h9E, 8'h01);
        check_pins("R10 bit set, bit 3 ignored");
        bus_read(8'h96, "R11 bit read one");
        bus_read(8'h94, "R11 bit read zero");
        bus_read(8'hB1, "R11 bit read of input port");
        bus_write(8'hE0, 8'h01);
        bus_read(8'hF0, "R11 port 7 reads zero");
        check_pins("R10 port 6 write ignored");

        // R2: address changes while strobe high, last one wins
        @(negedge clk); ale = 1'b1; ad_in = 8'h07;
        @(negedge clk); ad_in = 8'h01;
        @(negedge clk); ale = 1'b0; ad_in = 8'h09;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        check(ad_out === m_data[1], "R2 last address while strobe high",
              64'(ad_out), 64'(m_data[1]));
        rd_n = 1'b1; cs_n = 1'b1;

        // R5: hold write strobe, data changes, last value wins
        set_addr(8'h02);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; ad_in = 8'h11;
        @(negedge clk); ad_in = 8'h77;
        @(negedge clk); @(negedge clk);
        check(pins_out[15:8] === m_data[2], "R5 no update while strobe low",
              64'(pins_out[15:8]), 64'(m_data[2]));
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        model_write(8'h02, 8'h77);
        check_pins("R5 last data committed");

        // R3: write aborted by select, read without select
        set_addr(8'h01);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; ad_in = 8'h00;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        check_pins("R3 aborted write");
        rd_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(ad_oe === 1'b0, "R3 no drive without select", 64'(ad_oe), 64'd0);
        rd_n = 1'b1;

        // random phase
        for (int n = 0; n < 120; n++) begin
            case ($urandom % 3)
                0: a = 8'($urandom % 10);
                1: a = 8'h80 | 8'(($urandom % 6) << 4) | 8'($urandom % 16);
                default: a = ($urandom % 2) ? 8'h80 | 8'h60 | 8'($urandom % 16)
                                            : 8'(10 + $urandom % 6);
            endcase
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin
                pins_in = {8'($urandom), 8'($urandom), 8'($urandom),
                           8'($urandom), 8'($urandom)};
                pa_view = 8'($urandom);
            end
            bus_write(a, d);
            bus_read(a, "R9 R10 R11 random readback");
            if (n % 10 == 0) begin
                check_pins("R6 random pins");
                check_taps();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule